// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Lock

This block is a watchdog peripheral that sits on an APB slave port and takes 32-bit word accesses. A down-counter advances on each cycle where a watchdog clock enable is high. Software programs a reload value and two enables, one for the interrupt and one for the reset request. When the count first runs out, a raw interrupt flag is set and counting restarts from the reload value. If the count runs out again before software clears that flag, a reset request is latched and the counter halts. The reset request stays latched until the block itself is reset.

A lock register guards the configuration. Writing a fixed 32-bit key unlocks the block, and writing any other value locks it. While the block is locked, only the lock register accepts writes. An integration-test mode lets software drive the interrupt and reset outputs directly from a register.

The parameter `LITE` selects a reduced variant. In that variant the test registers do not exist, and once the interrupt enable has been set the control register cannot be written again until reset.

Top module: `wdt_apb`

## Requirements
- R1: After reset the reload value and the counter are 0xFFFFFFFF and the counter runs. Control, raw flag, reset request, lock, test control and test output are all 0.
- R2: A write to offset 0x000 loads the written value into both the reload register and the counter, and starts the counter. Offset 0x000 reads back the reload value and offset 0x004 reads the current count.
- R3: While the counter runs, each cycle with `wdog_ce` high decrements it by one. A step taken at a count of 1 or 0 is an expiry. An expiry with the raw flag clear sets the flag (read at offset 0x010, bit 0) and reloads the counter.
- R4: An expiry while the raw flag is set latches the reset request, forces the count to 0 and stops the counter. Only a write to offset 0x000 restarts counting, and the request is never cleared except by reset.
- R5: Any write to offset 0x00C clears the raw flag and reloads the counter from the reload value. This takes priority over an expiry in the same cycle.
- R6: Control sits at offset 0x008. Bit 0 is the interrupt enable and bit 1 is the reset enable, and all other bits read 0. `irq_o` and the masked status at offset 0x014 equal the raw flag AND bit 0. `rst_req_o` equals the reset request AND bit 1.
- R7: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and any other value locks it. Offset 0xC00 reads 1 when locked and 0 when unlocked. While locked, writes to every other offset have no effect.
- R8: In the full variant, bit 0 at offset 0xF00 enables test mode and reads back. While it is set, `rst_req_o` follows bit 0 and `irq_o` follows bit 1 of the write-only test output at offset 0xF04.
- R9: With LITE=1, a control write is ignored once control bit 0 is 1. Offsets 0xF00 and 0xF04 read 0, and writes to them have no effect on the outputs.
- R10: The write-only offsets 0x00C and 0xF04 and all unmapped offsets read 0. Writes to 0x004, 0x010, 0x014 or unmapped offsets change nothing. `pready` is always 1 and `pslverr` always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdog_ce | input | 1 | Count enable for the down-counter |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | Watchdog reset request |

## Verification
The counter is run with the enable held high, with the enable off, and with the enable high only every third cycle. Comparing these shows that the counter steps only on enabled cycles. A reload value of 0 separates the "expire at 0" path from the normal 1-to-0 step. Letting one timeout go unserviced, and then servicing it with an interrupt-clear write, shows the difference between the interrupt stage and the reset stage. Two instances, one full and one `LITE`, receive the same bus traffic, so the frozen control register and the missing test registers show up as a divergence between them that the model predicts.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W       = 32;
  localparam int OFF_RELOAD   = 'h000;
  localparam int OFF_COUNT    = 'h004;
  localparam int OFF_CTRL     = 'h008;
  localparam int OFF_CLEAR    = 'h00C;
  localparam int OFF_RAW      = 'h010;
  localparam int OFF_MASKED   = 'h014;
  localparam int OFF_LOCK     = 'hC00;
  localparam int OFF_TCTRL    = 'hF00;
  localparam int OFF_TOUT     = 'hF04;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr_we,
  input  logic             pend,
  output logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic             running;
  logic             run_n;
  logic [CNT_W-1:0] cnt_n, reload_n;

  assign expire = running & ce & (cnt <= CNT_W'(1)) & ~load_we & ~clr_we;

  always_comb begin
    cnt_n    = cnt;
    run_n    = running;
    reload_n = reload;
    if (load_we) begin
      reload_n = load_val;
      cnt_n    = load_val;
      run_n    = 1'b1;
    end else if (clr_we) begin
      cnt_n = reload;
    end else if (expire) begin
      if (pend) begin
        cnt_n = '0;
        run_n = 1'b0;
      end else begin
        cnt_n = reload;
      end
    end else if (running && ce) begin
      cnt_n = cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '1;
      reload  <= '1;
      running <= 1'b1;
    end else begin
      cnt     <= cnt_n;
      reload  <= reload_n;
      running <= run_n;
    end
  end

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && ce && cnt > CNT_W'(1) && !load_we && !clr_we) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load_we && !clr_we) |=> $stable(cnt));

  // R4
  second_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && pend) |=> (!running && cnt == '0));
endmodule

// File: rtl/wdt_flags.sv
module wdt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_we,
  output logic raw,
  output logic res
);
  logic raw_n, res_n;

  always_comb begin
    raw_n = raw;
    if (clr_we)                raw_n = 1'b0;
    else if (expire && !raw)   raw_n = 1'b1;
    res_n = res | (expire & raw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= 1'b0;
      res <= 1'b0;
    end else begin
      raw <= raw_n;
      res <= res_n;
    end
  end

  // R4
  res_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) res |=> res);

  // R5
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) clr_we |=> !raw);
endmodule

// File: rtl/wdt_outsel.sv
module wdt_outsel (
  input  logic       raw,
  input  logic       res,
  input  logic [1:0] ctrl,
  input  logic       tmode,
  input  logic [1:0] tout,
  output logic       irq,
  output logic       rst_req
);
  always_comb begin
    if (tmode) begin
      irq     = tout[1];
      rst_req = tout[0];
    end else begin
      irq     = raw & ctrl[0];
      rst_req = res & ctrl[1];
    end
  end
endmodule

// File: rtl/wdt_apb.sv
module wdt_apb
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32,
  parameter bit LITE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdog_ce,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic             wr_en, open_wr;
  logic             sel_reload, sel_count, sel_ctrl, sel_clear, sel_raw;
  logic             sel_masked, sel_lock, sel_tctrl, sel_tout;
  logic             load_we, clr_we, ctrl_we;
  logic [1:0]       ctrl_q, ctrl_n;
  logic             lock_q, lock_n;
  logic             tmode;
  logic [1:0]       tout;
  logic [CNT_W-1:0] reload, cnt;
  logic             expire, raw, res;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assign wr_en      = psel & penable & pwrite;
  assign open_wr    = wr_en & ~lock_q;
  assign sel_reload = (paddr == ADDR_W'(OFF_RELOAD));
  assign sel_count  = (paddr == ADDR_W'(OFF_COUNT));
  assign sel_ctrl   = (paddr == ADDR_W'(OFF_CTRL));
  assign sel_clear  = (paddr == ADDR_W'(OFF_CLEAR));
  assign sel_raw    = (paddr == ADDR_W'(OFF_RAW));
  assign sel_masked = (paddr == ADDR_W'(OFF_MASKED));
  assign sel_lock   = (paddr == ADDR_W'(OFF_LOCK));
  assign sel_tctrl  = (paddr == ADDR_W'(OFF_TCTRL));
  assign sel_tout   = (paddr == ADDR_W'(OFF_TOUT));

  assign load_we = open_wr & sel_reload;
  assign clr_we  = open_wr & sel_clear;
  assign ctrl_we = open_wr & sel_ctrl & ~(LITE & ctrl_q[0]);

  always_comb begin
    ctrl_n = ctrl_we ? pwdata[1:0] : ctrl_q;
    lock_n = (wr_en && sel_lock) ? (pwdata != UNLOCK_KEY) : lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lock_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      lock_q <= lock_n;
    end
  end

  generate
    if (LITE) begin : g_no_test
      assign tmode = 1'b0;
      assign tout  = 2'b00;
    end else begin : g_test
      logic       tmode_q, tmode_n;
      logic [1:0] tout_q, tout_n;
      always_comb begin
        tmode_n = (open_wr && sel_tctrl) ? pwdata[0]   : tmode_q;
        tout_n  = (open_wr && sel_tout)  ? pwdata[1:0] : tout_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tmode_q <= 1'b0;
          tout_q  <= '0;
        end else begin
          tmode_q <= tmode_n;
          tout_q  <= tout_n;
        end
      end
      assign tmode = tmode_q;
      assign tout  = tout_q;
    end
  endgenerate

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ce(wdog_ce), .load_we(load_we),
    .load_val(pwdata[CNT_W-1:0]), .clr_we(clr_we), .pend(raw),
    .reload(reload), .cnt(cnt), .expire(expire)
  );

  wdt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr_we(clr_we),
    .raw(raw), .res(res)
  );

  wdt_outsel u_out (
    .raw(raw), .res(res), .ctrl(ctrl_q), .tmode(tmode), .tout(tout),
    .irq(irq_o), .rst_req(rst_req_o)
  );

  always_comb begin
    prdata = '0;
    if (sel_reload)      prdata = DATA_W'(reload);
    else if (sel_count)  prdata = DATA_W'(cnt);
    else if (sel_ctrl)   prdata = DATA_W'(ctrl_q);
    else if (sel_raw)    prdata = DATA_W'(raw);
    else if (sel_masked) prdata = DATA_W'(raw & ctrl_q[0]);
    else if (sel_lock)   prdata = DATA_W'(lock_q);
    else if (sel_tctrl)  prdata = DATA_W'(tmode);
  end

  // R7
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && !sel_lock) |=> ($stable(ctrl_q) && $stable(reload)));

  // R9
  lite_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LITE && ctrl_q[0]) |=> ctrl_q[0]);

  // R10
  bus_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psel |-> (pready && !pslverr));
endmodule

// File: tb/wdt_apb_tb.sv
`timescale 1ns/1ps
module wdt_apb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wdog_ce = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata_l;
  logic        pready, pslverr, pready_l, pslverr_l;
  logic        irq_o, rst_req_o, irq_l, rst_l;

  int total = 0, bad = 0;
  int ce_mode = 0;
  int ce_phase = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdt_apb #(.LITE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .wdog_ce(wdog_ce), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  wdt_apb #(.LITE(1'b1)) u_dut_lite (
    .clk(clk), .rst_n(rst_n), .wdog_ce(wdog_ce), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_l),
    .pready(pready_l), .pslverr(pslverr_l), .irq_o(irq_l), .rst_req_o(rst_l)
  );

  // behavioural model, index 0 = full, 1 = lite
  logic [31:0] m_reload[2], m_cnt[2];
  bit          m_run[2], m_raw[2], m_res[2], m_lock[2], m_tm[2];
  bit   [1:0]  m_ctrl[2], m_tout[2];

  function automatic logic [31:0] m_read(int v, logic [11:0] a);
    case (a)
      12'h000: return m_reload[v];
      12'h004: return m_cnt[v];
      12'h008: return {30'd0, m_ctrl[v]};
      12'h010: return {31'd0, m_raw[v]};
      12'h014: return {31'd0, m_raw[v] & m_ctrl[v][0]};
      12'hC00: return {31'd0, m_lock[v]};
      12'hF00: return {31'd0, m_tm[v]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit m_irq(int v);
    return m_tm[v] ? m_tout[v][1] : (m_raw[v] & m_ctrl[v][0]);
  endfunction

  function automatic bit m_rst(int v);
    return m_tm[v] ? m_tout[v][0] : (m_res[v] & m_ctrl[v][1]);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    ce_phase <= ce_phase + 1;
    case (ce_mode)
      0: wdog_ce <= 1'b0;
      1: wdog_ce <= 1'b1;
      default: wdog_ce <= (ce_phase % 3 == 0);
    endcase
  end

  always @(posedge clk) begin
    for (int v = 0; v < 2; v++) begin
      if (!rst_n) begin
        m_reload[v] = 32'hFFFFFFFF; m_cnt[v] = 32'hFFFFFFFF; m_run[v] = 1;
        m_raw[v] = 0; m_res[v] = 0; m_lock[v] = 0; m_tm[v] = 0;
        m_ctrl[v] = 0; m_tout[v] = 0;
      end else begin
        bit we, ok;
        we = psel && penable && pwrite;
        ok = we && !m_lock[v];
        if (ok && paddr == 12'h000) begin
          m_reload[v] = pwdata; m_cnt[v] = pwdata; m_run[v] = 1;
        end else if (ok && paddr == 12'h00C) begin
          m_raw[v] = 0; m_cnt[v] = m_reload[v];
        end else if (m_run[v] && wdog_ce) begin
          if (m_cnt[v] <= 1) begin
            if (!m_raw[v]) begin
              m_raw[v] = 1; m_cnt[v] = m_reload[v];
            end else begin
              m_res[v] = 1; m_run[v] = 0; m_cnt[v] = 0;
            end
          end else m_cnt[v] = m_cnt[v] - 1;
        end
        if (ok && paddr == 12'h008 && !(v == 1 && m_ctrl[v][0])) m_ctrl[v] = pwdata[1:0];
        if (ok && v == 0 && paddr == 12'hF00) m_tm[v] = pwdata[0];
        if (ok && v == 0 && paddr == 12'hF04) m_tout[v] = pwdata[1:0];
        if (we && paddr == 12'hC00) m_lock[v] = (pwdata != 32'h1ACCE551);
      end
    end
    #1;
    if (rst_n) begin
      check("R6 irq full", {31'd0, irq_o}, {31'd0, m_irq(0)});
      check("R9 irq lite", {31'd0, irq_l}, {31'd0, m_irq(1)});
      check("R4 rst full", {31'd0, rst_req_o}, {31'd0, m_rst(0)});
      check("R4 rst lite", {31'd0, rst_l}, {31'd0, m_rst(1)});
      check("R10 resp", {30'd0, pready & pready_l, pslverr | pslverr_l}, 32'd2);
      if (psel && !pwrite) begin
        check("R10 prdata full", prdata, m_read(0, paddr));
        check("R10 prdata lite", prdata_l, m_read(1, paddr));
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, output logic [31:0] dl);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata; dl = prdata_l;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ce_mode = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d, dl;
    do_reset();
    // R1 reset state
    rd(12'h000, d, dl); check("R1 reload", d, 32'hFFFFFFFF);
    rd(12'h004, d, dl); check("R1 count", d, 32'hFFFFFFFF);
    rd(12'h008, d, dl); check("R1 ctrl", d, 0);
    rd(12'hC00, d, dl); check("R1 lock", d, 0);
    rd(12'h010, d, dl); check("R1 raw", d, 0);
    check("R1 outputs", {30'd0, irq_o, rst_req_o}, 0);

    // R2 load with enable off
    wr(12'h000, 32'd5);
    rd(12'h004, d, dl); check("R2 count loaded", d, 32'd5);
    rd(12'h000, d, dl); check("R2 reload", d, 32'd5);

    // R3 R4 unserviced timeout, enable always on
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h008, d, dl); check("R6 ctrl two bits", d, 32'd3);
    ce_mode = 1;
    idle(30);
    check("R4 reset latched", {31'd0, rst_req_o}, 1);
    rd(12'h004, d, dl); check("R4 count halted", d, 0);
    rd(12'h014, d, dl); check("R6 masked", d, 1);
    wr(12'h008, 32'd0);
    check("R6 rst gated", {30'd0, irq_o, rst_req_o}, 0);

    // R5 service by clear
    do_reset();
    wr(12'h000, 32'd4);
    wr(12'h008, 32'd1);
    ce_mode = 1;
    idle(6);
    check("R3 first expiry irq", {31'd0, irq_o}, 1);
    wr(12'h00C, 32'd0);
    check("R5 irq cleared", {31'd0, irq_o}, 0);
    for (int k = 0; k < 5; k++) begin
      idle(2); wr(12'h00C, 32'd7);
    end
    rd(12'h00C, d, dl); check("R10 clear reads zero", d, 0);

    // R3 every third cycle, reload zero
    do_reset();
    ce_mode = 2;
    wr(12'h000, 32'd0);
    wr(12'h008, 32'd3);
    idle(20);
    check("R3 zero reload reaches reset", {31'd0, rst_req_o}, 1);

    // R7 lock
    do_reset();
    wr(12'hC00, 32'd0);
    rd(12'hC00, d, dl); check("R7 locked reads 1", d, 1);
    wr(12'h008, 32'd1);
    wr(12'h000, 32'd9);
    rd(12'h008, d, dl); check("R7 ctrl blocked", d, 0);
    rd(12'h000, d, dl); check("R7 reload blocked", d, 32'hFFFFFFFF);
    wr(12'hC00, 32'h1ACCE551);
    rd(12'hC00, d, dl); check("R7 unlocked reads 0", d, 0);
    wr(12'h008, 32'd1);
    rd(12'h008, d, dl); check("R7 ctrl after unlock", d, 1);

    // R9 lite control freeze
    wr(12'h008, 32'd2);
    rd(12'h008, d, dl);
    check("R9 full ctrl rewritten", d, 2);
    check("R9 lite ctrl frozen", dl, 1);

    // R8 test mode
    wr(12'hF00, 32'd1);
    wr(12'hF04, 32'd2);
    check("R8 irq driven", {30'd0, irq_o, rst_req_o}, 32'd2);
    check("R9 lite ignores test", {30'd0, irq_l, rst_l}, 0);
    wr(12'hF04, 32'd1);
    check("R8 rst driven", {30'd0, irq_o, rst_req_o}, 32'd1);
    rd(12'hF00, d, dl); check("R8 tctrl reads", d, 1); check("R9 lite tctrl zero", dl, 0);
    rd(12'hF04, d, dl); check("R10 tout reads zero", d, 0);
    wr(12'hF00, 32'd0);

    // R10 read-only and unmapped
    wr(12'h000, 32'd50);
    wr(12'h004, 32'd3);
    wr(12'h010, 32'd1);
    wr(12'h100, 32'hDEAD);
    rd(12'h004, d, dl); check("R10 count unaffected", d, 32'd50);
    rd(12'h100, d, dl); check("R10 unmapped zero", d, 0);
    rd(12'h010, d, dl); check("R10 raw unaffected", d, 0);

    idle(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule